// File: doc/BRIEF.md
# Interlaced Video Sync Pulse Generator

This block produces the horizontal and vertical sync pins for an interlaced standard-definition video stream. It runs its own pixel and line counters on the pixel clock. The frame is split into an odd field and an even field. The horizontal pulse sits between two programmable pixel positions. These positions wrap modulo the line length, so software can move the pulse earlier by adding the line length minus the shift, or later by adding the shift. The polarity of the horizontal pin is selectable.

The vertical sync pin starts on a fixed line of each field and stops on a later fixed line. Within those lines, each of the two edges is placed either at the line start or at mid-line. This choice is made separately for each edge and each field. The line start is taken from either the HS begin position or the HS end position, and mid-line lies half a line after that point. All configuration is copied into shadow registers only at the frame boundary, so a sync pulse is never cut short or glitched by a write in the middle of a frame. The recommended settings are: HS active high, reference at the HS end, odd-field VS begin at mid-line, and the other three VS edges at line start.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst` is high, `hs_o` equals `cfg_hs_pol_i`, and `vs_o` and `field_o` are 0. After reset is released, the outputs seen after the k-th rising edge describe pixel k-1 of the frame, counting from line 0, pixel 0.
- R2: The pixel count runs from 0 to LINE_LEN-1 and then advances the line. The line count runs from 0 to FRAME_LINES-1 and then wraps to 0. `field_o` is 0 for lines below ODD_LINES (odd field) and 1 for the rest (even field).
- R3: The HS begin and end values are first reduced modulo LINE_LEN, which needs one subtraction at most. HS is active on pixels p with begin <= p < end. When end < begin, the pulse spans the wrap of the line. When begin equals end, HS is never active.
- R4: `hs_o` is active high when the polarity bit is 0 and active low when it is 1.
- R5: The reference position is the reduced HS end when `cfg_vs_ref_hsb_i` is 0, and the reduced HS begin when it is 1. The mid-line position is the reference plus LINE_LEN/2, reduced modulo LINE_LEN.
- R6: On relative line VS_BEG_LINE of a field, `vs_o` becomes 1 at the pixel that equals the begin position. That position is the reference when the field's begin-select bit is 1 and mid-line when it is 0.
- R7: On relative line VS_END_LINE of a field, `vs_o` returns to 0 at the end position. That position is the reference when the field's end-select bit is 1 and mid-line when it is 0.
- R8: All configuration inputs are sampled on the last pixel of the frame and take effect from pixel 0 of line 0. A change at any other time has no effect on the outputs until then.
- R9: The four VS edge-select bits act independently. Each one affects only its own edge in its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hsb_i | input | POS_W | HS begin position in pixel clocks |
| cfg_hse_i | input | POS_W | HS end position in pixel clocks |
| cfg_hs_pol_i | input | 1 | HS polarity: 0 active high, 1 active low |
| cfg_vs_ref_hsb_i | input | 1 | VS line-start reference: 0 HS end, 1 HS begin |
| cfg_vsb_odd_start_i | input | 1 | Odd-field VS begin: 1 line start, 0 mid-line |
| cfg_vsb_even_start_i | input | 1 | Even-field VS begin: 1 line start, 0 mid-line |
| cfg_vse_odd_start_i | input | 1 | Odd-field VS end: 1 line start, 0 mid-line |
| cfg_vse_even_start_i | input | 1 | Even-field VS end: 1 line start, 0 mid-line |
| hs_o | output | 1 | Horizontal sync pin, registered |
| vs_o | output | 1 | Vertical sync pin, active high, registered |
| field_o | output | 1 | Field indicator: 0 odd, 1 even, registered |

## Verification
The bench builds the block with a 40-pixel line, an 11-line frame split 6/5 between the fields, 6-bit positions, and VS spanning relative lines 1 to 3. With these values a whole frame takes 440 cycles, so many frames and configuration changes fit in a short run. The 6-bit positions can also exceed the line length, which exercises the modulo reduction, the wrapped HS pulse and a mid-line point that wraps past the line end. Configuration is changed at offsets that drift through the frame, so writes land mid-line and mid-field, and the frame-boundary sampling is tested from many phases.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  typedef struct packed {
    logic hs_pol;
    logic vs_ref_hsb;
    logic vsb_odd_start;
    logic vsb_even_start;
    logic vse_odd_start;
    logic vse_even_start;
  } sync_mode_t;

  typedef enum logic {
    FIELD_ODD  = 1'b0,
    FIELD_EVEN = 1'b1
  } field_e;

endpackage

// File: rtl/sync_timebase.sv
module sync_timebase
  import sync_gen_pkg::*;
#(
  parameter int LINE_LEN    = 1716,
  parameter int FRAME_LINES = 525,
  parameter int ODD_LINES   = 263,
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q,
  output logic              frame_last,
  output field_e            field,
  output logic [LINE_W-1:0] rel_line
);

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(LINE_LEN - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);
  localparam logic [LINE_W-1:0] ODD_N     = LINE_W'(ODD_LINES);

  logic line_end;

  assign line_end   = (pix_q == PIX_LAST);
  assign frame_last = line_end && (line_q == LINE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (line_end) begin
      pix_q  <= '0;
      line_q <= frame_last ? '0 : line_q + 1'b1;
    end else begin
      pix_q <= pix_q + 1'b1;
    end
  end

  always_comb begin
    if (line_q >= ODD_N) begin
      field    = FIELD_EVEN;
      rel_line = line_q - ODD_N;
    end else begin
      field    = FIELD_ODD;
      rel_line = line_q;
    end
  end

endmodule

// File: rtl/sync_cfg_shadow.sv
module sync_cfg_shadow
  import sync_gen_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int POS_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [POS_W-1:0] cfg_hsb,
  input  logic [POS_W-1:0] cfg_hse,
  input  sync_mode_t       cfg_mode,
  output logic [POS_W-1:0] hsb_q,
  output logic [POS_W-1:0] hse_q,
  output sync_mode_t       mode_q
);

  localparam logic [POS_W:0] LEN_X = (POS_W + 1)'(LINE_LEN);

  logic [1:0][POS_W-1:0] raw_pos;
  logic [1:0][POS_W-1:0] red_pos;

  assign raw_pos[0] = cfg_hsb;
  assign raw_pos[1] = cfg_hse;

  // positions larger than the line fold back once (2**POS_W < 2*LINE_LEN)
  for (genvar gi = 0; gi < 2; gi++) begin : g_wrap
    logic [POS_W:0] ext;
    logic [POS_W:0] dif;
    assign ext = {1'b0, raw_pos[gi]};
    assign dif = ext - LEN_X;
    assign red_pos[gi] = (ext >= LEN_X) ? dif[POS_W-1:0] : raw_pos[gi];
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      hsb_q  <= red_pos[0];
      hse_q  <= red_pos[1];
      mode_q <= cfg_mode;
    end
  end

endmodule

// File: rtl/sync_hpos.sv
module sync_hpos
  import sync_gen_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int POS_W    = 11,
  parameter int PIX_W    = 11
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [POS_W-1:0] hsb,
  input  logic [POS_W-1:0] hse,
  input  sync_mode_t       mode,
  input  field_e           field,
  output logic             hs_act,
  output logic [POS_W-1:0] vs_beg_pos,
  output logic [POS_W-1:0] vs_end_pos
);

  localparam logic [POS_W:0] LEN_X  = (POS_W + 1)'(LINE_LEN);
  localparam logic [POS_W:0] HALF_X = (POS_W + 1)'(LINE_LEN / 2);

  logic [POS_W-1:0] pix_x;
  logic [POS_W-1:0] ref_pos;
  logic [POS_W:0]   mid_sum;
  logic [POS_W:0]   mid_dif;
  logic [POS_W-1:0] mid_pos;
  logic [1:0]       at_start;
  logic [1:0][POS_W-1:0] edge_pos;

  assign pix_x = POS_W'(pix);

  always_comb begin
    if (hsb <= hse) hs_act = (pix_x >= hsb) && (pix_x < hse);
    else            hs_act = (pix_x >= hsb) || (pix_x < hse);
  end

  assign ref_pos = mode.vs_ref_hsb ? hsb : hse;
  assign mid_sum = {1'b0, ref_pos} + HALF_X;
  assign mid_dif = mid_sum - LEN_X;
  assign mid_pos = (mid_sum >= LEN_X) ? mid_dif[POS_W-1:0] : mid_sum[POS_W-1:0];

  assign at_start[0] = (field == FIELD_EVEN) ? mode.vsb_even_start : mode.vsb_odd_start;
  assign at_start[1] = (field == FIELD_EVEN) ? mode.vse_even_start : mode.vse_odd_start;

  for (genvar ge = 0; ge < 2; ge++) begin : g_edge
    assign edge_pos[ge] = at_start[ge] ? ref_pos : mid_pos;
  end

  assign vs_beg_pos = edge_pos[0];
  assign vs_end_pos = edge_pos[1];

endmodule

// File: rtl/sync_vs_ctrl.sv
module sync_vs_ctrl #(
  parameter int POS_W       = 11,
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int VS_BEG_LINE = 3,
  parameter int VS_END_LINE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] rel_line,
  input  logic [POS_W-1:0]  beg_pos,
  input  logic [POS_W-1:0]  end_pos,
  output logic              vs_q
);

  localparam logic [LINE_W-1:0] BEG_L = LINE_W'(VS_BEG_LINE);
  localparam logic [LINE_W-1:0] END_L = LINE_W'(VS_END_LINE);

  logic set_ev;
  logic clr_ev;

  assign set_ev = (rel_line == BEG_L) && (POS_W'(pix) == beg_pos);
  assign clr_ev = (rel_line == END_L) && (POS_W'(pix) == end_pos);

  always_ff @(posedge clk) begin
    if (rst)         vs_q <= 1'b0;
    else if (set_ev) vs_q <= 1'b1;
    else if (clr_ev) vs_q <= 1'b0;
  end

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_gen_pkg::*;
#(
  parameter int LINE_LEN    = 1716,
  parameter int FRAME_LINES = 525,
  parameter int ODD_LINES   = 263,
  parameter int POS_W       = 11,
  parameter int VS_BEG_LINE = 3,
  parameter int VS_END_LINE = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] cfg_hsb_i,
  input  logic [POS_W-1:0] cfg_hse_i,
  input  logic             cfg_hs_pol_i,
  input  logic             cfg_vs_ref_hsb_i,
  input  logic             cfg_vsb_odd_start_i,
  input  logic             cfg_vsb_even_start_i,
  input  logic             cfg_vse_odd_start_i,
  input  logic             cfg_vse_even_start_i,
  output logic             hs_o,
  output logic             vs_o,
  output logic             field_o
);

  localparam int PIX_W  = $clog2(LINE_LEN);
  localparam int LINE_W = $clog2(FRAME_LINES);

  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] rel_line;
  logic              frame_last;
  field_e            field;
  sync_mode_t        cfg_mode;
  sync_mode_t        mode_q;
  logic [POS_W-1:0]  hsb_q;
  logic [POS_W-1:0]  hse_q;
  logic              hs_act;
  logic [POS_W-1:0]  vs_beg_pos;
  logic [POS_W-1:0]  vs_end_pos;

  always_comb begin
    cfg_mode.hs_pol         = cfg_hs_pol_i;
    cfg_mode.vs_ref_hsb     = cfg_vs_ref_hsb_i;
    cfg_mode.vsb_odd_start  = cfg_vsb_odd_start_i;
    cfg_mode.vsb_even_start = cfg_vsb_even_start_i;
    cfg_mode.vse_odd_start  = cfg_vse_odd_start_i;
    cfg_mode.vse_even_start = cfg_vse_even_start_i;
  end

  sync_timebase #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .ODD_LINES(ODD_LINES),
    .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_timebase (
    .clk(clk), .rst(rst), .pix_q(pix_q), .line_q(line_q),
    .frame_last(frame_last), .field(field), .rel_line(rel_line)
  );

  sync_cfg_shadow #(
    .LINE_LEN(LINE_LEN), .POS_W(POS_W)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(frame_last),
    .cfg_hsb(cfg_hsb_i), .cfg_hse(cfg_hse_i), .cfg_mode(cfg_mode),
    .hsb_q(hsb_q), .hse_q(hse_q), .mode_q(mode_q)
  );

  sync_hpos #(
    .LINE_LEN(LINE_LEN), .POS_W(POS_W), .PIX_W(PIX_W)
  ) u_hpos (
    .pix(pix_q), .hsb(hsb_q), .hse(hse_q), .mode(mode_q), .field(field),
    .hs_act(hs_act), .vs_beg_pos(vs_beg_pos), .vs_end_pos(vs_end_pos)
  );

  sync_vs_ctrl #(
    .POS_W(POS_W), .PIX_W(PIX_W), .LINE_W(LINE_W),
    .VS_BEG_LINE(VS_BEG_LINE), .VS_END_LINE(VS_END_LINE)
  ) u_vs (
    .clk(clk), .rst(rst), .pix(pix_q), .rel_line(rel_line),
    .beg_pos(vs_beg_pos), .end_pos(vs_end_pos), .vs_q(vs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o    <= cfg_hs_pol_i;
      field_o <= 1'b0;
    end else begin
      hs_o    <= hs_act ^ mode_q.hs_pol;
      field_o <= (field == FIELD_EVEN);
    end
  end

endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk
  import sync_gen_pkg::*;
#(
  parameter int LINE_LEN    = 1716,
  parameter int FRAME_LINES = 525,
  parameter int ODD_LINES   = 263,
  parameter int POS_W       = 11,
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int VS_BEG_LINE = 3,
  parameter int VS_END_LINE = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [PIX_W-1:0]  pix_q,
  input logic [LINE_W-1:0] line_q,
  input logic              frame_last,
  input logic [POS_W-1:0]  hsb_q,
  input logic [POS_W-1:0]  hse_q,
  input sync_mode_t        mode_q,
  input logic              vs_o,
  input logic              field_o
);

  localparam logic [PIX_W-1:0]  PIX_LAST = PIX_W'(LINE_LEN - 1);
  localparam logic [PIX_W-1:0]  PIX_MAX  = PIX_W'(LINE_LEN - 1);
  localparam logic [LINE_W-1:0] ODD_N    = LINE_W'(ODD_LINES);
  localparam logic [LINE_W-1:0] BEG_O    = LINE_W'(VS_BEG_LINE);
  localparam logic [LINE_W-1:0] BEG_E    = LINE_W'(ODD_LINES + VS_BEG_LINE);
  localparam logic [LINE_W-1:0] END_O    = LINE_W'(VS_END_LINE);
  localparam logic [LINE_W-1:0] END_E    = LINE_W'(ODD_LINES + VS_END_LINE);

  AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pix_q <= PIX_MAX);  // R2

  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pix_q == PIX_LAST) |=> (pix_q == '0));  // R2

  AST_FIELD_TRACKS_LINE: assert property (@(posedge clk) disable iff (rst)
    field_o == ($past(line_q) >= ODD_N));  // R2

  AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> ($stable(hsb_q) && $stable(hse_q) && $stable(mode_q)));  // R8

  AST_VS_RISE_ON_BEG_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_o) |-> ($past(line_q) == BEG_O || $past(line_q) == BEG_E));  // R6

  AST_VS_FALL_ON_END_LINE: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_o) |-> ($past(line_q) == END_O || $past(line_q) == END_E));  // R7

endmodule

bind sync_pulse_gen sync_gen_chk #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .ODD_LINES(ODD_LINES),
  .POS_W(POS_W), .PIX_W(PIX_W), .LINE_W(LINE_W),
  .VS_BEG_LINE(VS_BEG_LINE), .VS_END_LINE(VS_END_LINE)
) u_chk (
  .clk(clk), .rst(rst), .pix_q(pix_q), .line_q(line_q),
  .frame_last(frame_last), .hsb_q(hsb_q), .hse_q(hse_q),
  .mode_q(mode_q), .vs_o(vs_o), .field_o(field_o)
);

// File: tb/test_sync_pulse_gen.sv
`timescale 1ns/1ps
module test_sync_pulse_gen;

  localparam int L  = 40;
  localparam int F  = 11;
  localparam int OD = 6;
  localparam int PW = 6;
  localparam int VB = 1;
  localparam int VE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] hsb = '0;
  logic [PW-1:0] hse = '0;
  logic pol = 1'b0, refb = 1'b0, vbo = 1'b0, vbe = 1'b1, veo = 1'b1, vee = 1'b1;
  logic hs_o, vs_o, field_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // reference model state
  int m_pix, m_line;
  int s_hsb, s_hse;
  bit s_pol, s_ref, s_vbo, s_vbe, s_veo, s_vee;
  bit e_hs, e_vs, e_field;

  always #2.5 clk = ~clk;

  sync_pulse_gen #(
    .LINE_LEN(L), .FRAME_LINES(F), .ODD_LINES(OD), .POS_W(PW),
    .VS_BEG_LINE(VB), .VS_END_LINE(VE)
  ) i_sync_pulse_gen (
    .clk(clk), .rst(rst), .cfg_hsb_i(hsb), .cfg_hse_i(hse),
    .cfg_hs_pol_i(pol), .cfg_vs_ref_hsb_i(refb),
    .cfg_vsb_odd_start_i(vbo), .cfg_vsb_even_start_i(vbe),
    .cfg_vse_odd_start_i(veo), .cfg_vse_even_start_i(vee),
    .hs_o(hs_o), .vs_o(vs_o), .field_o(field_o)
  );

  function automatic int fold(input int v);
    return (v >= L) ? v - L : v;
  endfunction

  task automatic latch_cfg();
    s_hsb = fold(int'(hsb)); s_hse = fold(int'(hse));
    s_pol = pol; s_ref = refb; s_vbo = vbo; s_vbe = vbe; s_veo = veo; s_vee = vee;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_pix = 0; m_line = 0;
      latch_cfg();
      e_hs = pol; e_vs = 1'b0; e_field = 1'b0;
    end else begin
      bit fld, act, bsel, esel;
      int rel, rp, mid, bp, ep;
      fld = (m_line >= OD);
      rel = fld ? m_line - OD : m_line;
      act = (s_hsb <= s_hse) ? (m_pix >= s_hsb && m_pix < s_hse)
                             : (m_pix >= s_hsb || m_pix < s_hse);
      e_hs = act ^ s_pol;
      rp   = s_ref ? s_hsb : s_hse;
      mid  = (rp + L / 2) % L;
      bsel = fld ? s_vbe : s_vbo;
      esel = fld ? s_vee : s_veo;
      bp   = bsel ? rp : mid;
      ep   = esel ? rp : mid;
      if (rel == VB && m_pix == bp) e_vs = 1'b1;
      else if (rel == VE && m_pix == ep) e_vs = 1'b0;
      e_field = fld;
      if (m_pix == L - 1 && m_line == F - 1) latch_cfg();
      if (m_pix == L - 1) begin
        m_pix = 0;
        m_line = (m_line == F - 1) ? 0 : m_line + 1;
      end else begin
        m_pix = m_pix + 1;
      end
    end
  end

  task automatic check_bit(input string tag, input string name, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check_bit(cur_tag, "hs_o", hs_o, e_hs);
      check_bit(cur_tag, "vs_o", vs_o, e_vs);
      check_bit("R2", "field_o", field_o, e_field);
    end
  end

  task automatic run_phase(input string tag, input int b, input int e, input bit p,
                           input bit r, input bit bo, input bit be, input bit eo,
                           input bit ee, input int cycles);
    @(negedge clk);
    cur_tag = tag;
    hsb = PW'(b); hse = PW'(e); pol = p; refb = r;
    vbo = bo; vbe = be; veo = eo; vee = ee;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset levels
    check_bit("R1", "hs_o", hs_o, pol);
    check_bit("R1", "vs_o", vs_o, 1'b0);
    check_bit("R1", "field_o", field_o, 1'b0);
    rst = 1'b0;
    repeat (2 * L * F) @(negedge clk);
    // R3: plain window, then a wrapped one, then folded values and an empty pulse
    run_phase("R3", 2, 10, 0, 0, 0, 1, 1, 1, 2 * L * F + 17);
    run_phase("R3", 35, 5, 0, 0, 0, 1, 1, 1, 2 * L * F + 23);
    run_phase("R3", 45, 62, 0, 0, 0, 1, 1, 1, 2 * L * F + 9);
    run_phase("R3", 7, 7, 0, 0, 0, 1, 1, 1, 2 * L * F + 31);
    // R4: inverted polarity
    run_phase("R4", 4, 12, 1, 0, 0, 1, 1, 1, 2 * L * F + 13);
    // R6: begin edges at mid-line in both fields, mid-line wraps past line end
    run_phase("R6", 30, 36, 0, 0, 0, 0, 1, 1, 2 * L * F + 5);
    // R7: end edges at mid-line in both fields
    run_phase("R7", 3, 9, 0, 0, 1, 1, 0, 0, 2 * L * F + 27);
    // R5: reference switched to HS begin
    run_phase("R5", 25, 33, 0, 1, 0, 1, 0, 1, 2 * L * F + 11);
    // R9: each edge select chosen differently per field
    run_phase("R9", 6, 14, 0, 0, 1, 0, 0, 1, 2 * L * F + 19);
    run_phase("R9", 6, 14, 0, 1, 0, 1, 1, 0, 2 * L * F + 3);
    // R8: rapid mid-frame changes that must wait for the frame boundary
    run_phase("R8", 10, 20, 1, 1, 1, 1, 0, 0, 57);
    run_phase("R8", 50, 2, 0, 0, 0, 0, 1, 1, 101);
    run_phase("R8", 18, 39, 1, 0, 1, 0, 1, 0, 2 * L * F + 7);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule